// File: doc/BRIEF.md
# Supervisor Control Register Bank

This block holds the small set of machine-control registers that only supervisor code may touch. The registers are the status word, the exception return address, the trap vector base, the trap cause, the timer compare value, two scratch words and the vector-bank enable mask. A fixed core number and an implementation number are also readable. Software reaches them through a 5-bit index and one of four operations: plain read, swap, bit-set and bit-clear. Every access hands back the value the register held before the access, so a read-modify-write cannot be split by any other access.

Some writes have side effects beyond storage. A status write asks for a translation-cache flush. A compare write drops the pending timer interrupt. A write to the clear-IPI index drops the pending inter-processor interrupt. A write to the send-IPI index emits the written value as the target core number. Two values are derived continuously from the stored state. One is the population count of the vector-bank mask. The other is a flag giving the active integer width, which comes from the supervisor bit and the matching 64-bit enable.

Top module: `ctlreg_bank`

## Requirements
- R1: A read (op 0) returns the old register value and changes nothing. Index 10 reads the CORE_ID parameter, index 11 reads 1, and both ignore writes. Indices this bank does not hold (2, 4, 7, 14-17, 19-31) read all ones and ignore writes.
- R2: Swap (op 1) stores the write operand and returns the previous value.
- R3: Set (op 2) stores old OR operand, and clear (op 3) stores old AND NOT operand. Both return the old value.
- R4: Status (index 0) keeps only bits 8:0 and 23:16. All other bits read zero. Bit 3 (compressed) is forced to zero when HAS_RVC=0. Bits 6 and 7 are forced to zero when HAS_64=0, bit 1 when HAS_FPU=0, and bit 2 when HAS_VEC=0.
- R5: A request with sup_i low pulses priv_fault_o for one cycle. It returns zero data, keeps rvalid_o low, changes no register and raises no side-effect strobe.
- R6: rdata_o and rvalid_o are registered. They are valid in the cycle after the request cycle, and rvalid_o is a one-cycle pulse.
- R7: Any write op (swap, set or clear) to index 5 (compare) pulses timer_clr_o. Any write op to index 9 pulses ipi_clr_o.
- R8: Any write op to index 8 pulses ipi_send_o and places the computed write value on ipi_target_o. This index reads as all ones, so set gives all ones.
- R9: Any write op to index 0 pulses tlb_flush_o. Reads do not.
- R10: The vector-bank register (index 18) keeps only bits 7:0. bank_count_o equals the number of ones in it.
- R11: wide_mode_o equals status bit 7 (supervisor 64-bit) when status bit 5 (supervisor) is 1, and status bit 6 (user 64-bit) otherwise.
- R12: After reset, status holds bits 0, 5, 7 and 23:16 (after the R4 filter). The trap vector holds EVEC_RESET. All other stored registers and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| op_i | input | 2 | 0 read, 1 swap, 2 set, 3 clear |
| idx_i | input | 5 | Register index |
| wdata_i | input | XLEN | Swap operand or set/clear mask |
| sup_i | input | 1 | Requester is in supervisor mode |
| rdata_o | output | XLEN | Old value of the accessed register |
| rvalid_o | output | 1 | rdata_o valid pulse |
| priv_fault_o | output | 1 | Privilege fault pulse |
| ipi_send_o | output | 1 | Send inter-processor interrupt |
| ipi_target_o | output | XLEN | Target core number for ipi_send_o |
| ipi_clr_o | output | 1 | Clear pending IPI |
| timer_clr_o | output | 1 | Clear pending timer interrupt |
| tlb_flush_o | output | 1 | Flush translation cache after status write |
| wide_mode_o | output | 1 | Active integer width is 64 bits |
| bank_count_o | output | $clog2(XLEN+1) | Number of enabled vector banks |

## Verification
Read data, the fault pulse and all four side-effect strobes are due in the first cycle after the request edge, since each passes through exactly one register. The stored-register update lands on that same edge. wide_mode_o and bank_count_o are combinational from stored state, so they also reflect a write one cycle after the request. The bench drives each request on a falling edge, drops it on the next falling edge, and samples there, in the single cycle where the pulses are high. An idle cycle then confirms that each pulse has fallen again.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SWAP  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } ctl_op_e;

    localparam logic [4:0] IDX_STATUS  = 5'd0;
    localparam logic [4:0] IDX_EPC     = 5'd1;
    localparam logic [4:0] IDX_EVEC    = 5'd3;
    localparam logic [4:0] IDX_COMPARE = 5'd5;
    localparam logic [4:0] IDX_CAUSE   = 5'd6;
    localparam logic [4:0] IDX_IPI_TX  = 5'd8;
    localparam logic [4:0] IDX_IPI_CLR = 5'd9;
    localparam logic [4:0] IDX_COREID  = 5'd10;
    localparam logic [4:0] IDX_IMPL    = 5'd11;
    localparam logic [4:0] IDX_SCR0    = 5'd12;
    localparam logic [4:0] IDX_SCR1    = 5'd13;
    localparam logic [4:0] IDX_VBANK   = 5'd18;

    // status bit positions
    localparam int ST_TRAP_EN = 0;
    localparam int ST_FPU     = 1;
    localparam int ST_VEC     = 2;
    localparam int ST_RVC     = 3;
    localparam int ST_PREV_S  = 4;
    localparam int ST_SUP     = 5;
    localparam int ST_U64     = 6;
    localparam int ST_S64     = 7;
    localparam int ST_VM      = 8;
    localparam int ST_IM_LO   = 16;
    localparam int ST_IM_HI   = 23;

    localparam logic [31:0] ST_KEEP = 32'h00FF_01FF;

    function automatic logic [31:0] status_mask(bit has64, bit hasfpu, bit hasrvc, bit hasvec);
        logic [31:0] m;
        m = ST_KEEP;
        if (!has64) begin
            m[ST_U64] = 1'b0;
            m[ST_S64] = 1'b0;
        end
        if (!hasfpu) m[ST_FPU] = 1'b0;
        if (!hasrvc) m[ST_RVC] = 1'b0;
        if (!hasvec) m[ST_VEC] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/ctlreg_rmw.sv
module ctlreg_rmw import ctlreg_pkg::*; #(
    parameter int W = 64
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] new_o,
    output logic         wr_o
);
    always_comb begin
        unique case (ctl_op_e'(op_i))
            OP_SWAP:  new_o = opnd_i;
            OP_SET:   new_o = old_i | opnd_i;
            OP_CLEAR: new_o = old_i & ~opnd_i;
            default:  new_o = old_i;
        endcase
        wr_o = (ctl_op_e'(op_i) != OP_READ);
    end
endmodule

// File: rtl/ctlreg_status_filter.sv
module ctlreg_status_filter import ctlreg_pkg::*; #(
    parameter int W       = 64,
    parameter bit HAS_64  = 1'b1,
    parameter bit HAS_FPU = 1'b1,
    parameter bit HAS_RVC = 1'b0,
    parameter bit HAS_VEC = 1'b1
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] clean_o
);
    localparam logic [31:0]  MASK32 = status_mask(HAS_64, HAS_FPU, HAS_RVC, HAS_VEC);
    localparam logic [W-1:0] MASK   = W'(MASK32);

    assign clean_o = raw_i & MASK;
endmodule

// File: rtl/ctlreg_popcount.sv
module ctlreg_popcount #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] partial [0:W];

    assign partial[0] = '0;
    for (genvar g = 0; g < W; g++) begin : g_acc
        assign partial[g+1] = partial[g] + CW'(bits_i[g]);
    end
    assign count_o = partial[W];
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank import ctlreg_pkg::*; #(
    parameter int             XLEN       = 64,
    parameter logic [XLEN-1:0] CORE_ID   = '0,
    parameter logic [XLEN-1:0] EVEC_RESET = XLEN'(32'h0000_2000),
    parameter bit             HAS_64     = 1'b1,
    parameter bit             HAS_FPU    = 1'b1,
    parameter bit             HAS_RVC    = 1'b0,
    parameter bit             HAS_VEC    = 1'b1,
    localparam int            BCW        = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [1:0]      op_i,
    input  logic [4:0]      idx_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            sup_i,
    output logic [XLEN-1:0] rdata_o,
    output logic            rvalid_o,
    output logic            priv_fault_o,
    output logic            ipi_send_o,
    output logic [XLEN-1:0] ipi_target_o,
    output logic            ipi_clr_o,
    output logic            timer_clr_o,
    output logic            tlb_flush_o,
    output logic            wide_mode_o,
    output logic [BCW-1:0]  bank_count_o
);
    localparam logic [XLEN-1:0] VBANK_MASK = XLEN'(8'hFF);
    localparam logic [XLEN-1:0] ST_RAW_RESET =
        XLEN'(32'h00FF_0000 | (32'd1 << ST_S64) | (32'd1 << ST_SUP) | (32'd1 << ST_TRAP_EN));
    localparam logic [XLEN-1:0] ST_RESET =
        ST_RAW_RESET & XLEN'(status_mask(HAS_64, HAS_FPU, HAS_RVC, HAS_VEC));

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] evec;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] compare;
        logic [XLEN-1:0] scratch0;
        logic [XLEN-1:0] scratch1;
        logic [XLEN-1:0] vbank;
        logic [XLEN-1:0] rdata;
        logic [XLEN-1:0] ipi_tgt;
        logic            rvalid;
        logic            fault;
        logic            tlb;
        logic            ipi_send;
        logic            ipi_clr;
        logic            tmr_clr;
    } regs_t;

    regs_t q, d;

    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic [XLEN-1:0] status_new;
    logic            op_writes;
    logic            grant;
    logic            do_write;

    // old-value selection
    always_comb begin
        unique case (idx_i)
            IDX_STATUS:  old_val = q.status;
            IDX_EPC:     old_val = q.epc;
            IDX_EVEC:    old_val = q.evec;
            IDX_COMPARE: old_val = q.compare;
            IDX_CAUSE:   old_val = q.cause;
            IDX_COREID:  old_val = CORE_ID;
            IDX_IMPL:    old_val = XLEN'(1);
            IDX_SCR0:    old_val = q.scratch0;
            IDX_SCR1:    old_val = q.scratch1;
            IDX_VBANK:   old_val = q.vbank;
            default:     old_val = '1;
        endcase
    end

    ctlreg_rmw #(.W(XLEN)) u_rmw (
        .op_i   (op_i),
        .old_i  (old_val),
        .opnd_i (wdata_i),
        .new_o  (new_val),
        .wr_o   (op_writes)
    );

    ctlreg_status_filter #(
        .W(XLEN), .HAS_64(HAS_64), .HAS_FPU(HAS_FPU),
        .HAS_RVC(HAS_RVC), .HAS_VEC(HAS_VEC)
    ) u_filter (
        .raw_i   (new_val),
        .clean_o (status_new)
    );

    ctlreg_popcount #(.W(XLEN)) u_popcnt (
        .bits_i  (q.vbank),
        .count_o (bank_count_o)
    );

    assign grant    = req_i & sup_i;
    assign do_write = grant & op_writes;

    // next-state
    always_comb begin
        d          = q;
        d.rvalid   = grant;
        d.fault    = req_i & ~sup_i;
        d.rdata    = grant ? old_val : '0;
        d.tlb      = 1'b0;
        d.ipi_send = 1'b0;
        d.ipi_clr  = 1'b0;
        d.tmr_clr  = 1'b0;
        if (do_write) begin
            unique case (idx_i)
                IDX_STATUS: begin
                    d.status = status_new;
                    d.tlb    = 1'b1;
                end
                IDX_EPC:     d.epc      = new_val;
                IDX_EVEC:    d.evec     = new_val;
                IDX_CAUSE:   d.cause    = new_val;
                IDX_COMPARE: begin
                    d.compare = new_val;
                    d.tmr_clr = 1'b1;
                end
                IDX_IPI_TX: begin
                    d.ipi_send = 1'b1;
                    d.ipi_tgt  = new_val;
                end
                IDX_IPI_CLR: d.ipi_clr  = 1'b1;
                IDX_SCR0:    d.scratch0 = new_val;
                IDX_SCR1:    d.scratch1 = new_val;
                IDX_VBANK:   d.vbank    = new_val & VBANK_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.status <= ST_RESET;
            q.evec   <= EVEC_RESET;
        end else begin
            q <= d;
        end
    end

    assign rdata_o      = q.rdata;
    assign rvalid_o     = q.rvalid;
    assign priv_fault_o = q.fault;
    assign ipi_send_o   = q.ipi_send;
    assign ipi_target_o = q.ipi_tgt;
    assign ipi_clr_o    = q.ipi_clr;
    assign timer_clr_o  = q.tmr_clr;
    assign tlb_flush_o  = q.tlb;
    assign wide_mode_o  = q.status[ST_SUP] ? q.status[ST_S64] : q.status[ST_U64];

endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk import ctlreg_pkg::*; #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic [1:0]      op_i,
    input logic [4:0]      idx_i,
    input logic            sup_i,
    input logic [XLEN-1:0] rdata_o,
    input logic            rvalid_o,
    input logic            priv_fault_o,
    input logic            ipi_send_o,
    input logic            ipi_clr_o,
    input logic            timer_clr_o,
    input logic            tlb_flush_o
);
    logic any_strobe;
    assign any_strobe = ipi_send_o | ipi_clr_o | timer_clr_o | tlb_flush_o;

    a_r6_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sup_i) |=> rvalid_o);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && sup_i) |=> !rvalid_o);

    a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !sup_i) |=> (priv_fault_o && !rvalid_o && !any_strobe && rdata_o == '0));

    a_r5_fault_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault_o |-> $past(req_i && !sup_i));

    a_r1_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'd0) |=> !any_strobe);

    a_r9_status_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sup_i && op_i != 2'd0 && idx_i == 5'd0) |=> tlb_flush_o);

    a_r7_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sup_i && op_i != 2'd0 && idx_i == 5'd5) |=> timer_clr_o);

    a_r7_ipi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sup_i && op_i != 2'd0 && idx_i == 5'd9) |=> ipi_clr_o);

    a_r8_ipi_send: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sup_i && op_i != 2'd0 && idx_i == 5'd8) |=> ipi_send_o);

    a_r4_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(idx_i) == 5'd0) |-> ((rdata_o[31:0] & ~ST_KEEP) == 32'd0));

endmodule

bind ctlreg_bank ctlreg_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .op_i         (op_i),
    .idx_i        (idx_i),
    .sup_i        (sup_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .priv_fault_o (priv_fault_o),
    .ipi_send_o   (ipi_send_o),
    .ipi_clr_o    (ipi_clr_o),
    .timer_clr_o  (timer_clr_o),
    .tlb_flush_o  (tlb_flush_o)
);

// File: tb/ctlreg_bank_tb.sv
module ctlreg_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int BCW  = $clog2(XLEN + 1);
    localparam logic [63:0] CID = 64'd5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic [1:0]      op_i = '0;
    logic [4:0]      idx_i = '0;
    logic [XLEN-1:0] wdata_i = '0;
    logic            sup_i = 1'b0;
    logic [XLEN-1:0] rdata_o;
    logic            rvalid_o, priv_fault_o, ipi_send_o, ipi_clr_o;
    logic            timer_clr_o, tlb_flush_o, wide_mode_o;
    logic [XLEN-1:0] ipi_target_o;
    logic [BCW-1:0]  bank_count_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_bank #(.XLEN(XLEN), .CORE_ID(CID)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .idx_i(idx_i),
        .wdata_i(wdata_i), .sup_i(sup_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .priv_fault_o(priv_fault_o), .ipi_send_o(ipi_send_o), .ipi_target_o(ipi_target_o),
        .ipi_clr_o(ipi_clr_o), .timer_clr_o(timer_clr_o), .tlb_flush_o(tlb_flush_o),
        .wide_mode_o(wide_mode_o), .bank_count_o(bank_count_o)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  idx;
        logic [63:0] wd;
        logic        sup;
        logic [63:0] exp;
        logic        fault;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 5'd0,  64'h0,                   1'b1, 64'h0000_0000_00FF_00A1, 1'b0}, // R12 status reset
        '{2'd0, 5'd3,  64'h0,                   1'b1, 64'h2000,                1'b0}, // R12 evec reset
        '{2'd1, 5'd1,  64'h1234_5678_9ABC_DEF0, 1'b1, 64'h0,                   1'b0}, // R2 swap epc
        '{2'd0, 5'd1,  64'h0,                   1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0}, // R1 read epc
        '{2'd2, 5'd12, 64'hF0,                  1'b1, 64'h0,                   1'b0}, // R3 set
        '{2'd2, 5'd12, 64'h0F,                  1'b1, 64'hF0,                  1'b0}, // R3 set
        '{2'd3, 5'd12, 64'h3C,                  1'b1, 64'hFF,                  1'b0}, // R3 clear
        '{2'd0, 5'd12, 64'h0,                   1'b1, 64'hC3,                  1'b0}, // R3 result
        '{2'd0, 5'd20, 64'h0,                   1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R1 unmapped
        '{2'd0, 5'd11, 64'h0,                   1'b1, 64'h1,                   1'b0}, // R1 impl
        '{2'd1, 5'd10, 64'h77,                  1'b1, 64'h5,                   1'b0}, // R1 core id swap
        '{2'd0, 5'd10, 64'h0,                   1'b1, 64'h5,                   1'b0}, // R1 core id kept
        '{2'd1, 5'd13, 64'hAA,                  1'b0, 64'h0,                   1'b1}, // R5 fault
        '{2'd0, 5'd13, 64'h0,                   1'b1, 64'h0,                   1'b0}, // R5 unchanged
        '{2'd1, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0000_0000_00FF_00A1, 1'b0}, // R4 write
        '{2'd0, 5'd0,  64'h0,                   1'b1, 64'h0000_0000_00FF_01F7, 1'b0}, // R4 filtered
        '{2'd1, 5'd18, 64'h1FF,                 1'b1, 64'h0,                   1'b0}, // R10 write
        '{2'd0, 5'd18, 64'h0,                   1'b1, 64'hFF,                  1'b0}, // R10 masked
        '{2'd3, 5'd0,  64'h20,                  1'b1, 64'h0000_0000_00FF_01F7, 1'b0}, // R3 clear S
        '{2'd0, 5'd0,  64'h0,                   1'b1, 64'h0000_0000_00FF_01D7, 1'b0}  // R3 result
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request; on return, outputs of that request are visible
    task automatic access(input logic [1:0] op, input logic [4:0] idx,
                          input logic [63:0] wd, input logic sup);
        @(negedge clk);
        req_i = 1'b1; op_i = op; idx_i = idx; wdata_i = wd; sup_i = sup;
        @(negedge clk);
        req_i = 1'b0; op_i = '0; idx_i = '0; wdata_i = '0; sup_i = 1'b0;
    endtask

    function automatic logic [3:0] strobes();
        return {tlb_flush_o, timer_clr_o, ipi_clr_o, ipi_send_o};
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rvalid", 64'(rvalid_o), 64'd0);
        check("R12 strobes", 64'({priv_fault_o, strobes()}), 64'd0);
        check("R11 wide at reset", 64'(wide_mode_o), 64'd1);
        check("R12 bank count", 64'(bank_count_o), 64'd0);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].op, TBL[i].idx, TBL[i].wd, TBL[i].sup);
            check($sformatf("R2/R3 vec%0d rdata", i), rdata_o, TBL[i].exp);
            check($sformatf("R5/R6 vec%0d fault", i), 64'(priv_fault_o), 64'(TBL[i].fault));
            check($sformatf("R6 vec%0d rvalid", i), 64'(rvalid_o), 64'(!TBL[i].fault));
        end

        // R11 width flag: S=0, U64=1 now
        check("R11 user64", 64'(wide_mode_o), 64'd1);
        access(2'd3, 5'd0, 64'h40, 1'b1);
        check("R11 user32", 64'(wide_mode_o), 64'd0);
        access(2'd2, 5'd0, 64'h20, 1'b1);
        check("R11 sup64", 64'(wide_mode_o), 64'd1);

        // R10 population count
        check("R10 count ff", 64'(bank_count_o), 64'd8);
        access(2'd1, 5'd18, 64'h05, 1'b1);
        check("R10 count 05", 64'(bank_count_o), 64'd2);

        // R7 strobes
        access(2'd1, 5'd5, 64'h100, 1'b1);
        check("R7 timer clear", 64'(strobes()), 64'b0100);
        @(negedge clk);
        check("R6 pulse ends", 64'({rvalid_o, strobes()}), 64'd0);
        access(2'd1, 5'd9, 64'h0, 1'b1);
        check("R7 ipi clear", 64'(strobes()), 64'b0010);
        access(2'd0, 5'd5, 64'h0, 1'b1);
        check("R7 compare kept", rdata_o, 64'h100);
        check("R1 read no strobe", 64'(strobes()), 64'd0);

        // R8 send-IPI
        access(2'd1, 5'd8, 64'd3, 1'b1);
        check("R8 send strobe", 64'(strobes()), 64'b0001);
        check("R8 target", ipi_target_o, 64'd3);
        access(2'd3, 5'd8, 64'hF0, 1'b1);
        check("R8 clear target", ipi_target_o, ~64'hF0);

        // R9 flush
        access(2'd2, 5'd0, 64'h1, 1'b1);
        check("R9 flush", 64'(strobes()), 64'b1000);
        access(2'd0, 5'd0, 64'h0, 1'b1);
        check("R9 read no flush", 64'(tlb_flush_o), 64'd0);

        // R5 non-supervisor write to compare: no strobe, no change
        access(2'd1, 5'd5, 64'h999, 1'b0);
        check("R5 fault no strobe", 64'({priv_fault_o, strobes()}), 64'b10000);
        access(2'd0, 5'd5, 64'h0, 1'b1);
        check("R5 compare unchanged", rdata_o, 64'h100);

        // R1 writes ignored at unmapped index
        access(2'd1, 5'd20, 64'h0, 1'b1);
        access(2'd0, 5'd20, 64'h0, 1'b1);
        check("R1 unmapped ignores write", rdata_o, 64'hFFFF_FFFF_FFFF_FFFF);

        done = 1'b1;
        finish_run();
    end
endmodule